// File: doc/BRIEF.md
# Monochrome Pixel Expander with Scissor Clipping

This block turns host-supplied monochrome transfer words into a stream of per-pixel write requests for a downstream mix unit. A start pulse latches a target rectangle (signed origin, inclusive last-column and last-row offsets, base address and row pitch). The block then asks for transfer words one at a time. It spends one clock on each bit, most-significant bit first. A 1 bit tells the mix unit to apply the foreground mix at that pixel, and a 0 bit asks for the background mix.

The walk runs left to right along a row. After the last column it returns to the origin column on the next row, and the address jumps to the start of that row. Every pixel is gated by an inclusive clipping window held in four 12-bit limit registers, and also by a check that both coordinates are non-negative. A clipped pixel still uses up its bit, its address step and its column step, but no request is raised for it. Software loads the four limits through a 16-bit indexed write port, where the upper nibble picks the limit, and reads them back through a select port. The operation ends after the last pixel of the last row. Any bits left over in the final word are dropped.

Top module: `mono_expand_clip`

## Requirements
- R1: A write on `mf_wr` whose `mf_wdata[15:12]` is 1, 2, 3 or 4 loads `mf_wdata[11:0]` into the top, left, bottom or right limit respectively, from the next cycle on. Any other nibble value changes no limit.
- R2: `mf_rdata` returns `{4'b0, limit}` for `mf_rsel` 1 (top), 2 (left), 3 (bottom) and 4 (right), and returns 0 for any other select. After reset, top and left are 0 and bottom and right are 4095.
- R3: Within each transfer word, the pixel slots use bits WORD_W-1 down to 0 in that order. The first slot after a word is accepted uses bit WORD_W-1.
- R4: `px_fg` is 1 in a slot whose transfer bit is 1 (foreground mix) and 0 in a slot whose bit is 0 (background mix).
- R5: When `cmd_swap` is 1 at start, the two bytes within each 16-bit half of every transfer word are exchanged before the bits are used. For a 32-bit word, bits [31:0] become {[23:16],[31:24],[7:0],[15:8]}.
- R6: `px_req` is 1 in a slot only if X ≥ 0, Y ≥ 0, left ≤ X ≤ right and top ≤ Y ≤ bottom, with all bounds inclusive. Otherwise the slot is skipped with `px_req` 0.
- R7: Each slot advances X by one and `px_addr` by one, whether or not the pixel was drawn. In row r and column c, the address is base + r·pitch + c and X is origin X + c.
- R8: After the slot in column `span_w`, the next slot is in column 0 of the next row: X returns to the origin, Y increases by one and the address moves to the start of the next row.
- R9: `busy` rises the cycle after a `start` while idle. It falls right after the slot at column `span_w` of row `span_h`, and unused bits of the last word are dropped. While idle, `px_slot` and `word_ready` are 0.
- R10: `word_ready` is 1 only while busy with no word in hand, and a `word_data` is taken only when `word_valid` and `word_ready` are both 1. `start` and the rectangle inputs are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mf_wr | input | 1 | Indexed limit write strobe |
| mf_wdata | input | 16 | Limit index in [15:12], value in [11:0] |
| mf_rsel | input | 3 | Limit read select |
| mf_rdata | output | 16 | Selected limit, zero-extended |
| start | input | 1 | Begin an expansion (ignored while busy) |
| cmd_swap | input | 1 | Swap the bytes within each 16-bit half of transfer words |
| org_x | input | COORD_W+1 | Signed rectangle origin X |
| org_y | input | COORD_W+1 | Signed rectangle origin Y |
| span_w | input | COORD_W | Last column offset (columns = span_w+1) |
| span_h | input | COORD_W | Last row offset (rows = span_h+1) |
| base_addr | input | ADDR_W | Address of the origin pixel |
| row_pitch | input | ADDR_W | Address distance between rows |
| word_valid | input | 1 | Transfer word offered |
| word_data | input | WORD_W | Monochrome transfer word |
| word_ready | output | 1 | Block will take a transfer word this cycle |
| busy | output | 1 | Expansion in progress |
| px_slot | output | 1 | A pixel position is being stepped this cycle |
| px_req | output | 1 | Write request to the mix unit for this slot |
| px_fg | output | 1 | 1 selects foreground mix, 0 background mix |
| px_addr | output | ADDR_W | Pixel address of the current slot |

## Verification
The assertions check on every cycle that a request never appears outside a slot, outside the inclusive window or at a negative coordinate. They also check that the address steps by one between adjacent slots within a row, that accepting a word and stepping a pixel never overlap, that the block is quiet when idle and goes busy after a start, and that the limit registers change only through an indexed write. Only the bench's scenarios can show the bit order, the byte swap and the row wrap addressing. The same holds for the exact point where busy drops, the discarding of leftover bits, the readback values and the fact that stray starts and words offered while busy leave the operation untouched.

// File: rtl/mec_pkg.sv
package mec_pkg;

    localparam int unsigned SCISSOR_W = 12;
    localparam int unsigned MF_W      = 16;

    // Upper-nibble index of an indexed limit write; same values select readback.
    typedef enum logic [3:0] {
        LIM_NONE   = 4'd0,
        LIM_TOP    = 4'd1,
        LIM_LEFT   = 4'd2,
        LIM_BOTTOM = 4'd3,
        LIM_RIGHT  = 4'd4
    } lim_idx_e;

    typedef struct packed {
        logic [SCISSOR_W-1:0] top;
        logic [SCISSOR_W-1:0] left;
        logic [SCISSOR_W-1:0] bottom;
        logic [SCISSOR_W-1:0] right;
    } scissor_t;

endpackage

// File: rtl/mec_scissor_regs.sv
module mec_scissor_regs
    import mec_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [MF_W-1:0] wdata,
    input  logic [2:0]      rsel,
    output logic [MF_W-1:0] rdata,
    output scissor_t        win
);

    localparam int unsigned PAD_W = MF_W - SCISSOR_W;

    scissor_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (wr) begin
            case (wdata[MF_W-1:SCISSOR_W])
                LIM_TOP:    win_d.top    = wdata[SCISSOR_W-1:0];
                LIM_LEFT:   win_d.left   = wdata[SCISSOR_W-1:0];
                LIM_BOTTOM: win_d.bottom = wdata[SCISSOR_W-1:0];
                LIM_RIGHT:  win_d.right  = wdata[SCISSOR_W-1:0];
                default:    win_d        = win_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q.top    <= '0;
            win_q.left   <= '0;
            win_q.bottom <= '1;
            win_q.right  <= '1;
        end else begin
            win_q <= win_d;
        end
    end

    always_comb begin
        case ({1'b0, rsel})
            LIM_TOP:    rdata = {{PAD_W{1'b0}}, win_q.top};
            LIM_LEFT:   rdata = {{PAD_W{1'b0}}, win_q.left};
            LIM_BOTTOM: rdata = {{PAD_W{1'b0}}, win_q.bottom};
            LIM_RIGHT:  rdata = {{PAD_W{1'b0}}, win_q.right};
            default:    rdata = '0;
        endcase
    end

    assign win = win_q;

endmodule

// File: rtl/mec_byte_swap.sv
module mec_byte_swap #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              en,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);

    localparam int unsigned HALF_W = 16;
    localparam int unsigned HALVES = WORD_W / HALF_W;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        localparam int unsigned LO = h * HALF_W;
        always_comb begin
            if (en) begin
                dout[LO +: 8]     = din[LO + 8 +: 8];
                dout[LO + 8 +: 8] = din[LO +: 8];
            end else begin
                dout[LO +: HALF_W] = din[LO +: HALF_W];
            end
        end
    end

endmodule

// File: rtl/mec_clip_test.sv
module mec_clip_test
    import mec_pkg::*;
#(
    parameter int unsigned XW = 14
) (
    input  logic signed [XW-1:0] x,
    input  logic signed [XW-1:0] y,
    input  scissor_t             win,
    output logic                 visible
);

    localparam int unsigned PAD_W = XW - SCISSOR_W;
    localparam logic signed [XW-1:0] ZERO = '0;

    logic signed [XW-1:0] lim_l, lim_r, lim_t, lim_b;
    logic                 nonneg, in_x, in_y;

    always_comb begin
        lim_l  = $signed({{PAD_W{1'b0}}, win.left});
        lim_r  = $signed({{PAD_W{1'b0}}, win.right});
        lim_t  = $signed({{PAD_W{1'b0}}, win.top});
        lim_b  = $signed({{PAD_W{1'b0}}, win.bottom});
        nonneg = (x >= ZERO) && (y >= ZERO);
        in_x   = (x >= lim_l) && (x <= lim_r);
        in_y   = (y >= lim_t) && (y <= lim_b);
        visible = nonneg && in_x && in_y;
    end

endmodule

// File: rtl/mono_expand_clip.sv
module mono_expand_clip
    import mec_pkg::*;
#(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned COORD_W = 12,
    parameter int unsigned ADDR_W  = 20
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mf_wr,
    input  logic [15:0]               mf_wdata,
    input  logic [2:0]                mf_rsel,
    output logic [15:0]               mf_rdata,
    input  logic                      start,
    input  logic                      cmd_swap,
    input  logic signed [COORD_W:0]   org_x,
    input  logic signed [COORD_W:0]   org_y,
    input  logic [COORD_W-1:0]        span_w,
    input  logic [COORD_W-1:0]        span_h,
    input  logic [ADDR_W-1:0]         base_addr,
    input  logic [ADDR_W-1:0]         row_pitch,
    input  logic                      word_valid,
    input  logic [WORD_W-1:0]         word_data,
    output logic                      word_ready,
    output logic                      busy,
    output logic                      px_slot,
    output logic                      px_req,
    output logic                      px_fg,
    output logic [ADDR_W-1:0]         px_addr
);

    localparam int unsigned XW    = COORD_W + 2;
    localparam int unsigned BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [BIT_W-1:0]     TOP_BIT = BIT_W'(WORD_W - 1);
    localparam logic signed [XW-1:0] X_ONE   = XW'(1);
    localparam logic [COORD_W-1:0]   C_ONE   = COORD_W'(1);
    localparam logic [ADDR_W-1:0]    A_ONE   = ADDR_W'(1);

    typedef struct packed {
        logic                   busy;
        logic                   loaded;
        logic                   swap;
        logic [WORD_W-1:0]      bits;
        logic [BIT_W-1:0]       idx;
        logic signed [XW-1:0]   x0;
        logic signed [XW-1:0]   x;
        logic signed [XW-1:0]   y;
        logic [COORD_W-1:0]     w;
        logic [COORD_W-1:0]     h;
        logic [COORD_W-1:0]     col;
        logic [COORD_W-1:0]     row;
        logic [ADDR_W-1:0]      pitch;
        logic [ADDR_W-1:0]      row_addr;
        logic [ADDR_W-1:0]      addr;
    } walk_t;

    walk_t st_d, st_q;

    scissor_t          win;
    logic [WORD_W-1:0] word_ordered;
    logic              visible;
    logic              last_col, last_row, last_bit;

    // Internal views for the bound checker.
    logic signed [XW-1:0] cur_x, cur_y;
    logic [COORD_W-1:0]   cur_col;

    mec_scissor_regs u_limits (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (mf_wr),
        .wdata (mf_wdata),
        .rsel  (mf_rsel),
        .rdata (mf_rdata),
        .win   (win)
    );

    mec_byte_swap #(.WORD_W(WORD_W)) u_swap (
        .en   (st_q.swap),
        .din  (word_data),
        .dout (word_ordered)
    );

    mec_clip_test #(.XW(XW)) u_clip (
        .x       (st_q.x),
        .y       (st_q.y),
        .win     (win),
        .visible (visible)
    );

    always_comb begin
        st_d     = st_q;
        last_col = (st_q.col == st_q.w);
        last_row = (st_q.row == st_q.h);
        last_bit = (st_q.idx == '0);

        if (!st_q.busy) begin
            if (start) begin
                st_d.busy     = 1'b1;
                st_d.loaded   = 1'b0;
                st_d.swap     = cmd_swap;
                st_d.x0       = {org_x[COORD_W], org_x};
                st_d.x        = {org_x[COORD_W], org_x};
                st_d.y        = {org_y[COORD_W], org_y};
                st_d.w        = span_w;
                st_d.h        = span_h;
                st_d.col      = '0;
                st_d.row      = '0;
                st_d.pitch    = row_pitch;
                st_d.row_addr = base_addr;
                st_d.addr     = base_addr;
            end
        end else if (!st_q.loaded) begin
            if (word_valid) begin
                st_d.loaded = 1'b1;
                st_d.bits   = word_ordered;
                st_d.idx    = TOP_BIT;
            end
        end else begin
            if (last_bit) begin
                st_d.loaded = 1'b0;
            end else begin
                st_d.idx = st_q.idx - 1'b1;
            end
            if (last_col) begin
                st_d.col      = '0;
                st_d.x        = st_q.x0;
                st_d.y        = st_q.y + X_ONE;
                st_d.row      = st_q.row + C_ONE;
                st_d.row_addr = st_q.row_addr + st_q.pitch;
                st_d.addr     = st_q.row_addr + st_q.pitch;
                if (last_row) begin
                    st_d.busy   = 1'b0;
                    st_d.loaded = 1'b0;
                end
            end else begin
                st_d.col  = st_q.col + C_ONE;
                st_d.x    = st_q.x + X_ONE;
                st_d.addr = st_q.addr + A_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy       = st_q.busy;
    assign word_ready = st_q.busy && !st_q.loaded;
    assign px_slot    = st_q.busy && st_q.loaded;
    assign px_req     = px_slot && visible;
    assign px_fg      = st_q.bits[st_q.idx];
    assign px_addr    = st_q.addr;

    assign cur_x   = st_q.x;
    assign cur_y   = st_q.y;
    assign cur_col = st_q.col;

endmodule

// File: rtl/mec_checks.sv
module mec_checks
    import mec_pkg::*;
#(
    parameter int unsigned XW      = 14,
    parameter int unsigned COORD_W = 12,
    parameter int unsigned ADDR_W  = 20
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 busy,
    input logic                 word_ready,
    input logic                 px_slot,
    input logic                 px_req,
    input logic [ADDR_W-1:0]    px_addr,
    input logic                 mf_wr,
    input logic [15:0]          mf_wdata,
    input scissor_t             win,
    input logic signed [XW-1:0] cur_x,
    input logic signed [XW-1:0] cur_y,
    input logic [COORD_W-1:0]   cur_col
);

    localparam int unsigned PAD_W = XW - SCISSOR_W;
    localparam logic signed [XW-1:0] ZERO = '0;

    logic signed [XW-1:0] e_l, e_r, e_t, e_b;
    assign e_l = $signed({{PAD_W{1'b0}}, win.left});
    assign e_r = $signed({{PAD_W{1'b0}}, win.right});
    assign e_t = $signed({{PAD_W{1'b0}}, win.top});
    assign e_b = $signed({{PAD_W{1'b0}}, win.bottom});

    AST_REQ_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        px_req |-> px_slot); // R6

    AST_REQ_INSIDE_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        px_req |-> (cur_x >= e_l && cur_x <= e_r && cur_y >= e_t && cur_y <= e_b)); // R6

    AST_NEG_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (px_slot && (cur_x < ZERO || cur_y < ZERO)) |-> !px_req); // R6

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (px_slot && $past(px_slot) && cur_col != '0) |-> px_addr == ADDR_W'($past(px_addr) + 1'b1)); // R7

    AST_READY_NOT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_ready && px_slot)); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!px_slot && !word_ready)); // R9

    AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R9

    AST_SCISSOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mf_wr |=> $stable(win)); // R1

    AST_TOP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_wr && mf_wdata[15:12] == 4'd1) |=> win.top == $past(mf_wdata[11:0])); // R1

endmodule

bind mono_expand_clip mec_checks #(
    .XW      (XW),
    .COORD_W (COORD_W),
    .ADDR_W  (ADDR_W)
) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .word_ready (word_ready),
    .px_slot    (px_slot),
    .px_req     (px_req),
    .px_addr    (px_addr),
    .mf_wr      (mf_wr),
    .mf_wdata   (mf_wdata),
    .win        (win),
    .cur_x      (cur_x),
    .cur_y      (cur_y),
    .cur_col    (cur_col)
);

// File: tb/mono_expand_clip_bench.sv
`timescale 1ns/1ps
module mono_expand_clip_bench;

    localparam int WORD_W  = 32;
    localparam int COORD_W = 12;
    localparam int ADDR_W  = 20;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    mf_wr = 1'b0;
    logic [15:0]             mf_wdata = '0;
    logic [2:0]              mf_rsel = '0;
    logic [15:0]             mf_rdata;
    logic                    start = 1'b0;
    logic                    cmd_swap = 1'b0;
    logic signed [COORD_W:0] org_x = '0;
    logic signed [COORD_W:0] org_y = '0;
    logic [COORD_W-1:0]      span_w = '0;
    logic [COORD_W-1:0]      span_h = '0;
    logic [ADDR_W-1:0]       base_addr = '0;
    logic [ADDR_W-1:0]       row_pitch = '0;
    logic                    word_valid = 1'b0;
    logic [WORD_W-1:0]       word_data = '0;
    logic                    word_ready, busy, px_slot, px_req, px_fg;
    logic [ADDR_W-1:0]       px_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench copy of the clipping window, kept from what the bench writes.
    int sc_t = 0, sc_l = 0, sc_b = 4095, sc_r = 4095;

    always #4 clk = ~clk;

    mono_expand_clip #(.WORD_W(WORD_W), .COORD_W(COORD_W), .ADDR_W(ADDR_W)) u_mono_expand_clip (
        .clk(clk), .rst_n(rst_n), .mf_wr(mf_wr), .mf_wdata(mf_wdata), .mf_rsel(mf_rsel),
        .mf_rdata(mf_rdata), .start(start), .cmd_swap(cmd_swap), .org_x(org_x), .org_y(org_y),
        .span_w(span_w), .span_h(span_h), .base_addr(base_addr), .row_pitch(row_pitch),
        .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready), .busy(busy),
        .px_slot(px_slot), .px_req(px_req), .px_fg(px_fg), .px_addr(px_addr)
    );

    typedef struct packed {
        int          x0;
        int          y0;
        int          w;
        int          h;
        bit          sw;
        logic [31:0] wd;
        int          exp_drawn;
    } vec_t;

    // Window used for the table: top 2, left 3, bottom 5, right 6.
    localparam vec_t TABLE [5] = '{
        '{x0:  3, y0:  2, w: 3, h: 3, sw: 1'b0, wd: 32'hA5C3_0000, exp_drawn: 16},
        '{x0:  1, y0:  1, w: 7, h: 3, sw: 1'b1, wd: 32'h1234_5678, exp_drawn: 12},
        '{x0: -2, y0: -1, w: 9, h: 2, sw: 1'b0, wd: 32'hFFFF_FFFF, exp_drawn:  0},
        '{x0:  6, y0:  5, w: 1, h: 1, sw: 1'b1, wd: 32'h00FF_F00F, exp_drawn:  1},
        '{x0: -1, y0:  3, w: 4, h: 4, sw: 1'b0, wd: 32'h8421_0F0F, exp_drawn:  3}
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] order_word(input logic [31:0] w, input bit sw);
        return sw ? {w[23:16], w[31:24], w[7:0], w[15:8]} : w;
    endfunction

    task automatic lim_write(input logic [15:0] v);
        @(negedge clk);
        mf_wr = 1'b1;
        mf_wdata = v;
        @(negedge clk);
        mf_wr = 1'b0;
    endtask

    task automatic lim_read(input int sel, input int exp, input string req);
        mf_rsel = 3'(sel);
        #1;
        chk(mf_rdata == 16'(exp), req, mf_rdata, exp);
    endtask

    task automatic run_op(input int x0, input int y0, input int w, input int h, input bit sw,
                          input int base, input int pitch, input logic [31:0] w0,
                          input logic [31:0] w1, input int exp_drawn, input string tag);
        int total, p, k, widx, drawn, guard;
        logic [31:0] cur;
        total = (w + 1) * (h + 1);
        p = 0; k = 0; widx = 0; drawn = 0; guard = 0; cur = '0;
        @(negedge clk);
        org_x = 13'(x0); org_y = 13'(y0); span_w = 12'(w); span_h = 12'(h);
        cmd_swap = sw; base_addr = 20'(base); row_pitch = 20'(pitch);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9 busy after start", busy, 1);
        // Junk on the rectangle inputs: must be ignored once latched (R10).
        org_x = -13'sd100; org_y = 13'sd7; span_w = '0; span_h = '0;
        cmd_swap = ~sw; base_addr = 20'h7; row_pitch = 20'h3;
        forever begin
            if (!busy || guard > 400) break;
            guard++;
            if (word_ready) begin
                start = 1'b0;
                word_valid = 1'b1;
                word_data = (widx == 0) ? w0 : w1;
                cur = order_word(word_data, sw);
                widx++;
                k = 0;
            end else if (px_slot) begin
                int col, row, ex, ey, ea;
                bit vis, efg;
                col = p % (w + 1);
                row = p / (w + 1);
                ex = x0 + col;
                ey = y0 + row;
                ea = base + row * pitch + col;
                efg = cur[31 - k];
                vis = (ex >= 0) && (ey >= 0) && (ex >= sc_l) && (ex <= sc_r) &&
                      (ey >= sc_t) && (ey <= sc_b);
                chk(px_addr == 20'(ea), {"R7/R8 addr ", tag}, px_addr, ea);
                chk(px_fg == efg, {"R3/R4/R5 fg ", tag}, px_fg, efg);
                chk(px_req == vis, {"R6 req ", tag}, px_req, vis);
                if (px_req) drawn++;
                p++;
                k++;
                // Stray word and start while busy (R10).
                word_valid = 1'b1;
                word_data = 32'hDEAD_BEEF;
                start = 1'b1;
            end
            @(negedge clk);
            word_valid = 1'b0;
        end
        start = 1'b0;
        word_valid = 1'b0;
        chk(p == total, {"R9 slot count ", tag}, p, total);
        chk(drawn == exp_drawn, {"R6 drawn count ", tag}, drawn, exp_drawn);
        chk(busy == 1'b0, {"R9 idle at end ", tag}, busy, 0);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R2, R9)
        chk(busy == 1'b0, "R9 reset busy", busy, 0);
        chk(px_slot == 1'b0, "R9 reset slot", px_slot, 0);
        chk(word_ready == 1'b0, "R10 reset ready", word_ready, 0);
        lim_read(1, 0, "R2 reset top");
        lim_read(2, 0, "R2 reset left");
        lim_read(3, 4095, "R2 reset bottom");
        lim_read(4, 4095, "R2 reset right");
        lim_read(0, 0, "R2 select 0");

        // Non-matching index nibbles change nothing (R1)
        lim_write(16'h5123);
        lim_write(16'h0ABC);
        lim_write(16'hF777);
        lim_read(1, 0, "R1 ignored write top");
        lim_read(2, 0, "R1 ignored write left");
        lim_read(3, 4095, "R1 ignored write bottom");
        lim_read(4, 4095, "R1 ignored write right");
        lim_read(5, 0, "R2 select 5");

        // Load the window (R1, R2)
        lim_write(16'h1002); lim_write(16'h2003);
        lim_write(16'h3005); lim_write(16'h4006);
        sc_t = 2; sc_l = 3; sc_b = 5; sc_r = 6;
        lim_read(1, 2, "R1 top load");
        lim_read(2, 3, "R1 left load");
        lim_read(3, 5, "R1 bottom load");
        lim_read(4, 6, "R1 right load");

        // Table walk
        foreach (TABLE[i]) begin
            run_op(TABLE[i].x0, TABLE[i].y0, TABLE[i].w, TABLE[i].h, TABLE[i].sw,
                   1000 + 64 * i, 40, TABLE[i].wd, 32'h0, TABLE[i].exp_drawn,
                   $sformatf("vec%0d", i));
        end

        // Two words, 42 pixels: 22 bits of the second word dropped (R3, R9)
        run_op(3, 2, 6, 5, 1'b0, 5000, 100, 32'hF0F0_1234, 32'h8040_2010, 16, "multiword");
        // Next operation starts at the MSB of a fresh word (R3)
        run_op(4, 4, 0, 0, 1'b0, 77, 1, 32'h8000_0000, 32'h0, 1, "single pixel");
        // Single row wider than a word, wrapping never reached until the end (R8)
        run_op(0, 3, 39, 0, 1'b1, 12, 9, 32'h0102_0408, 32'hFFFF_0000, 4, "long row");
        // Tall single column: every slot wraps to a new row (R8)
        run_op(5, 0, 0, 7, 1'b0, 300, 33, 32'h5500_0000, 32'h0, 4, "column");

        // Window opened fully, far corner pixel inclusive (R6)
        lim_write(16'h1000); lim_write(16'h2000);
        lim_write(16'h3FFF); lim_write(16'h4FFF);
        sc_t = 0; sc_l = 0; sc_b = 4095; sc_r = 4095;
        run_op(4094, 4094, 2, 2, 1'b0, 0, 8, 32'hFFFF_FFFF, 32'h0, 4, "far corner");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule